// File: doc/BRIEF.md
# Exception entry sequencer

This block carries a processor from the cycle in which a fault or an interrupt is accepted to the cycle in which the fetch of the handler's first instruction is issued. While it runs, a busy flag keeps the pipeline stalled. It first records the status register and forces supervisor state. Next it settles the vector number. It then pushes a two-word frame onto the supervisor stack, reads the handler address from the vector table and issues the fetch.

A fault carries a small type code, and the vector number and the choice of stacked program counter follow from that code alone. An interrupt carries a priority level and a vector number. A control input selects whether that vector is used as given, or whether an acknowledge read is made to an address that encodes the level, with the vector taken from the returned data. Every memory access uses one word-wide request/ready bus.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset `busy`, `bus_req` and `fetch_valid` are low. A request is accepted only while `busy` is low. `busy` rises on the next cycle, and fault or interrupt requests raised while it is high have no effect on the bus, the fetch output, `sr_out` or `ssp_out`.
- R2: For every accepted request, `sr_out` equals the sampled `sr_in` with bit 13 (supervisor) set and bit 15 (trace) cleared. For faults, all other bits are unchanged.
- R3: For an interrupt, `sr_out` additionally has bit 12 (master) cleared and bits 10:8 (priority mask) loaded with `irq_lvl`.
- R4: A fault of type t uses vector number t+2. When a fault and an interrupt are requested in the same cycle, the fault is taken and the interrupt is ignored.
- R5: For an interrupt with `ack_en` high, one read is made at `IACK_BASE + 4*irq_lvl`, and the vector number is bits 7:0 of the returned data. With `ack_en` low, no such read occurs and `irq_vec` is the vector number.
- R6: `ssp_out` equals `ssp_in` rounded down to a multiple of 4, minus 8. The first frame write goes to `ssp_out` with data {4'h4, ssp_in[1:0], 2'b00, vector[7:0], saved sr[15:0]} (bits 31 down to 0).
- R7: The second frame write goes to `ssp_out + 4` and holds the stacked program counter. That is `pc_next` for interrupts and for fault types whose bit is set in `NEXT_PC_MASK`, and `pc_fault` for all other fault types.
- R8: The vector read goes to `{vbr_in[31:20], 20'b0} | {vector, 2'b00}`: the low 20 bits of the vector base are ignored.
- R9: Bus accesses come in the fixed order acknowledge read (if any), frame high word, frame low word, vector read. Each access holds its address, direction and data unchanged until `bus_rdy` is seen, and no access is made while `busy` is low.
- R10: One cycle after the vector read completes, `fetch_valid` is high for exactly one cycle, with `fetch_addr` equal to the data returned by that read. `busy` is low on the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| flt_req | input | 1 | fault request |
| flt_type | input | 4 | fault type code |
| irq_req | input | 1 | interrupt request |
| irq_lvl | input | 3 | interrupt priority level |
| irq_vec | input | 8 | vector number supplied with the interrupt |
| ack_en | input | 1 | use an acknowledge read to obtain the interrupt vector |
| sr_in | input | 16 | current status register |
| pc_fault | input | 32 | address of the faulting instruction |
| pc_next | input | 32 | address of the next instruction |
| ssp_in | input | 32 | current supervisor stack pointer |
| vbr_in | input | 32 | vector base register |
| bus_req | output | 1 | bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | byte address |
| bus_wdata | output | 32 | write data |
| bus_rdata | input | 32 | read data, valid with bus_rdy |
| bus_rdy | input | 1 | access completes on this cycle |
| busy | output | 1 | sequence in progress; pipeline stall |
| sr_out | output | 16 | updated status register |
| ssp_out | output | 32 | new supervisor stack pointer |
| fetch_valid | output | 1 | one-cycle pulse issuing the handler fetch |
| fetch_addr | output | 32 | handler address |

## Verification
The bench builds the block with `NEXT_PC_MASK` set to 16'h0F00, so that fault types 8 to 11 stack the next address and the other types stack the faulting address. Fault types on both sides of that boundary are therefore reachable in a few runs. `IACK_BASE` and the 20-bit vector base alignment keep their defaults. The bench feeds vector bases with nonzero low bits to show that they are dropped, and it inserts bus wait states so that the hold-until-ready behaviour is exercised.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int SR_W    = 16;
    localparam int SR_T    = 15;
    localparam int SR_S    = 13;
    localparam int SR_M    = 12;
    localparam int IPL_LO  = 8;
    localparam int IPL_W   = 3;
    localparam int VEC_W   = 8;
    localparam int TYPE_W  = 4;
    localparam int WORD_W  = 32;
    localparam int FMT_W   = 4;
    localparam int ALIGN_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VNUM,
        ST_IACK,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_VREAD,
        ST_FETCH
    } st_e;

    typedef struct packed {
        st_e                st;
        logic               use_ack;
        logic [IPL_W-1:0]   lvl;
        logic [VEC_W-1:0]   vec;
        logic [SR_W-1:0]    sr_save;
        logic [SR_W-1:0]    sr_new;
        logic [WORD_W-1:0]  pc;
        logic [WORD_W-1:0]  sp;
        logic [ALIGN_W-1:0] align;
        logic [WORD_W-1:0]  handler;
    } seq_t;
endpackage

// File: rtl/exc_fault_map.sv
module exc_fault_map
    import exc_pkg::*;
#(
    parameter logic [(1<<TYPE_W)-1:0] NEXT_PC_MASK = '0
) (
    input  logic [TYPE_W-1:0] ftype,
    output logic [VEC_W-1:0]  vec,
    output logic              use_next
);
    localparam logic [VEC_W-1:0] VEC_OFS = VEC_W'(2);

    always_comb begin
        vec      = VEC_W'(ftype) + VEC_OFS;
        use_next = NEXT_PC_MASK[ftype];
    end
endmodule

// File: rtl/exc_sr_upd.sv
module exc_sr_upd
    import exc_pkg::*;
(
    input  logic [SR_W-1:0]  sr_in,
    input  logic             is_irq,
    input  logic [IPL_W-1:0] lvl,
    output logic [SR_W-1:0]  sr_new
);
    always_comb begin
        sr_new       = sr_in;
        sr_new[SR_S] = 1'b1;
        sr_new[SR_T] = 1'b0;
        if (is_irq) begin
            sr_new[SR_M]            = 1'b0;
            sr_new[IPL_LO +: IPL_W] = lvl;
        end
    end
endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen
    import exc_pkg::*;
#(
    parameter logic [WORD_W-1:0] IACK_BASE = 32'hFFFF_FFE0,
    parameter int                VBR_LSB   = 20
) (
    input  logic [WORD_W-1:0] vbr,
    input  logic [VEC_W-1:0]  vec,
    input  logic [IPL_W-1:0]  lvl,
    output logic [WORD_W-1:0] vec_addr,
    output logic [WORD_W-1:0] iack_addr
);
    localparam logic [WORD_W-1:0] BASE_MASK = ~((WORD_W'(1) << VBR_LSB) - WORD_W'(1));

    always_comb begin
        vec_addr  = (vbr & BASE_MASK) | {{(WORD_W-VEC_W-2){1'b0}}, vec, 2'b00};
        iack_addr = IACK_BASE + {{(WORD_W-IPL_W-2){1'b0}}, lvl, 2'b00};
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter logic [WORD_W-1:0]       IACK_BASE    = 32'hFFFF_FFE0,
    parameter logic [(1<<TYPE_W)-1:0]  NEXT_PC_MASK = 16'hC000,
    parameter int                      VBR_LSB      = 20,
    parameter logic [FMT_W-1:0]        FRAME_FMT    = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_req,
    input  logic [3:0]        flt_type,
    input  logic              irq_req,
    input  logic [2:0]        irq_lvl,
    input  logic [7:0]        irq_vec,
    input  logic              ack_en,
    input  logic [15:0]       sr_in,
    input  logic [31:0]       pc_fault,
    input  logic [31:0]       pc_next,
    input  logic [31:0]       ssp_in,
    input  logic [31:0]       vbr_in,
    output logic              bus_req,
    output logic              bus_we,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_rdy,
    output logic              busy,
    output logic [15:0]       sr_out,
    output logic [31:0]       ssp_out,
    output logic              fetch_valid,
    output logic [31:0]       fetch_addr
);
    localparam logic [WORD_W-1:0] FRAME_BYTES = WORD_W'(8);
    localparam logic [WORD_W-1:0] WORD_BYTES  = WORD_W'(4);

    seq_t seq_d, seq_q;

    logic [VEC_W-1:0]  flt_vec;
    logic              flt_next;
    logic [SR_W-1:0]   sr_upd;
    logic [WORD_W-1:0] vec_addr;
    logic [WORD_W-1:0] iack_addr;
    logic [WORD_W-1:0] frame_hi;

    exc_fault_map #(.NEXT_PC_MASK(NEXT_PC_MASK)) u_map (
        .ftype    (flt_type),
        .vec      (flt_vec),
        .use_next (flt_next)
    );

    exc_sr_upd u_sr (
        .sr_in  (sr_in),
        .is_irq (!flt_req),
        .lvl    (irq_lvl),
        .sr_new (sr_upd)
    );

    exc_addr_gen #(.IACK_BASE(IACK_BASE), .VBR_LSB(VBR_LSB)) u_addr (
        .vbr       (vbr_in),
        .vec       (seq_q.vec),
        .lvl       (seq_q.lvl),
        .vec_addr  (vec_addr),
        .iack_addr (iack_addr)
    );

    assign frame_hi = {FRAME_FMT, seq_q.align, 2'b00, seq_q.vec, seq_q.sr_save};

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (flt_req || irq_req) begin
                    seq_d.st      = ST_VNUM;
                    seq_d.use_ack = !flt_req && ack_en;
                    seq_d.lvl     = irq_lvl;
                    seq_d.vec     = flt_req ? flt_vec : irq_vec;
                    seq_d.sr_save = sr_in;
                    seq_d.sr_new  = sr_upd;
                    seq_d.pc      = (flt_req && !flt_next) ? pc_fault : pc_next;
                    seq_d.sp      = {ssp_in[WORD_W-1:2], 2'b00} - FRAME_BYTES;
                    seq_d.align   = ssp_in[ALIGN_W-1:0];
                end
            end
            ST_VNUM:    seq_d.st = seq_q.use_ack ? ST_IACK : ST_PUSH_HI;
            ST_IACK: begin
                if (bus_rdy) begin
                    seq_d.vec = bus_rdata[VEC_W-1:0];
                    seq_d.st  = ST_PUSH_HI;
                end
            end
            ST_PUSH_HI: if (bus_rdy) seq_d.st = ST_PUSH_LO;
            ST_PUSH_LO: if (bus_rdy) seq_d.st = ST_VREAD;
            ST_VREAD: begin
                if (bus_rdy) begin
                    seq_d.handler = bus_rdata;
                    seq_d.st      = ST_FETCH;
                end
            end
            ST_FETCH:   seq_d.st = ST_IDLE;
            default:    seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (seq_q.st)
            ST_IACK: begin
                bus_req  = 1'b1;
                bus_addr = iack_addr;
            end
            ST_PUSH_HI: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = seq_q.sp;
                bus_wdata = frame_hi;
            end
            ST_PUSH_LO: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = seq_q.sp + WORD_BYTES;
                bus_wdata = seq_q.pc;
            end
            ST_VREAD: begin
                bus_req  = 1'b1;
                bus_addr = vec_addr;
            end
            default: ;
        endcase
    end

    assign busy        = (seq_q.st != ST_IDLE);
    assign sr_out      = seq_q.sr_new;
    assign ssp_out     = seq_q.sp;
    assign fetch_valid = (seq_q.st == ST_FETCH);
    assign fetch_addr  = seq_q.handler;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flt_req,
    input logic        irq_req,
    input logic [2:0]  irq_lvl,
    input logic [15:0] sr_out,
    input logic [31:0] ssp_in,
    input logic [31:0] ssp_out,
    input logic        bus_req,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_rdy,
    input logic        busy,
    input logic        fetch_valid
);
    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req && !fetch_valid);

    // R10
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> !fetch_valid && !busy);

    // R2
    sr_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sr_out[13] && !sr_out[15]);

    // R3
    sr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && $past(irq_req) && !$past(flt_req) |-> !sr_out[12] && sr_out[10:8] == $past(irq_lvl));

    // R6
    sp_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ssp_out == (($past(ssp_in) & ~32'd3) - 32'd8));
endmodule

bind exc_entry_seq exc_entry_chk u_chk (.*);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
    localparam logic [31:0] IACK_BASE = 32'hFFFF_FFE0;
    localparam logic [15:0] NMASK     = 16'h0F00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_req = 1'b0, irq_req = 1'b0, ack_en = 1'b0;
    logic [3:0]  flt_type = '0;
    logic [2:0]  irq_lvl = '0;
    logic [7:0]  irq_vec = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] pc_fault = '0, pc_next = '0, ssp_in = '0, vbr_in = '0;
    logic        bus_req, bus_we, busy, fetch_valid;
    logic [31:0] bus_addr, bus_wdata, fetch_addr, ssp_out;
    logic [31:0] bus_rdata = '0;
    logic        bus_rdy = 1'b0;
    logic [15:0] sr_out;

    int total = 0;
    int bad = 0;
    int waits = 0;
    int wcnt = 0;

    typedef struct {
        int          kind;   // 0 write, 1 read, 2 fetch
        logic [31:0] addr;
        logic [31:0] data;
        logic [15:0] sr;
        logic [31:0] sp;
        string       rq;
    } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    exc_entry_seq #(.IACK_BASE(IACK_BASE), .NEXT_PC_MASK(NMASK)) u0 (.*);

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic item_t mk(input int k, input logic [31:0] a, input logic [31:0] d,
                                 input logic [15:0] s, input logic [31:0] p, input string rq);
        item_t it;
        it.kind = k; it.addr = a; it.data = d; it.sr = s; it.sp = p; it.rq = rq;
        return it;
    endfunction

    // driver: compute expectations from the requirements, then pulse the request
    task automatic run_exc(input bit flt, input bit irq, input logic [3:0] ft, input logic [2:0] lvl,
                           input logic [7:0] ivec, input bit ack, input logic [15:0] sr,
                           input logic [31:0] pcf, input logic [31:0] pcn, input logic [31:0] ssp,
                           input logic [31:0] vbr, input logic [7:0] avec, input logic [31:0] handler,
                           input bit intrude);
        logic [7:0]  vec;
        logic [15:0] srn;
        logic [31:0] sp, pc, va;
        vec = flt ? 8'(ft) + 8'd2 : (ack ? avec : ivec);               // R4 R5
        srn = (sr | 16'h2000) & ~16'h8000;                             // R2
        if (!flt) begin
            srn = srn & ~16'h1000;                                     // R3
            srn[10:8] = lvl;
        end
        sp = (ssp & ~32'd3) - 32'd8;                                   // R6
        pc = (flt && !NMASK[ft]) ? pcf : pcn;                          // R7
        va = (vbr & 32'hFFF0_0000) | {22'd0, vec, 2'b00};              // R8
        if (!flt && ack)
            exp_q.push_back(mk(1, IACK_BASE + {27'd0, lvl, 2'b00}, {24'hA5C3E1, avec}, '0, '0, "R5"));
        exp_q.push_back(mk(0, sp, {4'h4, ssp[1:0], 2'b00, vec, sr}, '0, '0, "R6"));
        exp_q.push_back(mk(0, sp + 32'd4, pc, '0, '0, "R7"));
        exp_q.push_back(mk(1, va, handler, '0, '0, "R8"));
        exp_q.push_back(mk(2, handler, '0, srn, sp, flt ? "R2" : "R3"));
        @(negedge clk);
        flt_req = flt; irq_req = irq; flt_type = ft; irq_lvl = lvl; irq_vec = ivec; ack_en = ack;
        sr_in = sr; pc_fault = pcf; pc_next = pcn; ssp_in = ssp; vbr_in = vbr;
        @(negedge clk);
        flt_req = 1'b0; irq_req = 1'b0;
        if (intrude) begin
            // R1: requests while busy must be ignored
            @(negedge clk);
            flt_req = 1'b1; irq_req = 1'b1; flt_type = 4'd1; ssp_in = 32'h0000_1000;
            sr_in = 16'h8000;
            @(negedge clk);
            flt_req = 1'b0; irq_req = 1'b0;
        end
        while (busy) @(negedge clk);
        check(exp_q.size() == 0, "R10 queue drained", 32'(exp_q.size()), 0);
        check(ssp_out == sp, "R1 ssp_out after run", ssp_out, sp);
    endtask

    // monitor / bus responder: pops expected items as the design produces them
    always @(negedge clk) begin
        item_t it;
        if (bus_rdy) begin
            bus_rdy = 1'b0;
        end else if (bus_req) begin
            if (wcnt < waits) begin
                wcnt++;
            end else begin
                wcnt = 0;
                if (exp_q.size() == 0 || exp_q[0].kind == 2) begin
                    check(0, "R9 unexpected bus access", bus_addr, 0);
                end else begin
                    it = exp_q.pop_front();
                    check(bus_we == (it.kind == 0), {it.rq, " R9 direction"}, 32'(bus_we), 32'(it.kind == 0));
                    check(bus_addr == it.addr, {it.rq, " address"}, bus_addr, it.addr);
                    if (it.kind == 0) check(bus_wdata == it.data, {it.rq, " write data"}, bus_wdata, it.data);
                    else bus_rdata = it.data;
                end
                bus_rdy = 1'b1;
            end
        end
        if (fetch_valid) begin
            if (exp_q.size() == 0 || exp_q[0].kind != 2) begin
                check(0, "R10 unexpected fetch", fetch_addr, 0);
            end else begin
                it = exp_q.pop_front();
                check(fetch_addr == it.addr, "R10 fetch address", fetch_addr, it.addr);
                check(sr_out == it.sr, it.rq, 32'(sr_out), 32'(it.sr));
                check(ssp_out == it.sp, "R6 ssp_out", ssp_out, it.sp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !bus_req && !fetch_valid, "R1 reset", {29'd0, busy, bus_req, fetch_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R4 R6 R7 R8: fault type 3 stacks faulting pc, aligned stack
        run_exc(1, 0, 4'd3, 3'd0, 8'h00, 0, 16'h8704, 32'h0000_4000, 32'h0000_4002,
                32'h0080_2000, 32'h0080_1234, 8'h00, 32'h0000_0410, 0);
        // R6 R7: fault type 9 stacks next pc, misaligned stack, with wait states (R9)
        waits = 2;
        run_exc(1, 0, 4'd9, 3'd0, 8'h00, 0, 16'h2000, 32'h0000_5000, 32'h0000_5004,
                32'h0080_2FFB, 32'h0000_0000, 8'h00, 32'h0000_0800, 0);
        // R3 R5: interrupt with acknowledge read, level 5
        run_exc(0, 1, 4'd0, 3'd5, 8'h11, 1, 16'h9200, 32'h0000_6000, 32'h0000_6008,
                32'h0080_3001, 32'h0080_0000, 8'h48, 32'h0000_1200, 0);
        // R5: interrupt without acknowledge, vector from request
        waits = 0;
        run_exc(0, 1, 4'd0, 3'd7, 8'h45, 0, 16'h0000, 32'h0000_7000, 32'h0000_7002,
                32'h0080_4000, 32'h00FF_FFFF, 8'h00, 32'h0000_1300, 0);
        // R3: master set, mask 7, trace set, level 1
        run_exc(0, 1, 4'd0, 3'd1, 8'h66, 0, 16'hB71F, 32'h0000_7100, 32'h0000_7104,
                32'h0080_4100, 32'h0000_0000, 8'h00, 32'h0000_1400, 0);
        // R4: fault and interrupt together, fault wins
        run_exc(1, 1, 4'd14, 3'd6, 8'h50, 1, 16'h0700, 32'h0000_8000, 32'h0000_8002,
                32'h0080_5002, 32'h0010_0000, 8'h00, 32'h0000_1500, 0);
        // R1: requests raised while busy are ignored
        waits = 1;
        run_exc(1, 0, 4'd0, 3'd0, 8'h00, 0, 16'h0001, 32'h0000_9000, 32'h0000_9002,
                32'h0080_6000, 32'h0000_0000, 8'h00, 32'h0000_1600, 1);
        repeat (4) @(negedge clk);
        check(!busy && !bus_req, "R1 idle after intrusion", {30'd0, busy, bus_req}, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule